// File: doc/BRIEF.md
# Two-Wire Fed Line-Code Modulator

This block turns the clock and data lines of a two-wire serial bus into a coded modulation signal for a coil damping stage. A neighbouring serial slave handles bus framing: it detects START and STOP, shifts in the command byte, drives its acknowledge, and then hands this block the byte with a one-cycle strobe. It also supplies single-cycle pulses for the rising and falling clock edges, the present data level, and a STOP pulse. All of these are synchronous to the system clock.

When the strobed command selects a modulator mode, the block enters a streaming state. Every later rising clock edge takes one bit from the data line. The bit is encoded as Manchester or as Bi-phase, and the choice comes from one bit of the command byte. Bits run on without a break: there is no acknowledge slot after each group of eight. A STOP ends streaming, drops the output to the undamped level, and returns the bus to normal use. The output level 1 means damp the coil and 0 means leave it undamped.

Top module: `coil_line_modulator`

## Requirements
- R1: After reset, `mod_out` is 0 and the block is not streaming.
- R2: A strobed command byte whose bits [7:5] are 110 and whose bits [2:0] are 111 starts streaming. Bit 4 picks the code (0 = Bi-phase, 1 = Manchester) and bit 3 has no effect. The output is 0 on entry.
- R3: A strobed command byte of any other value has no effect: `mod_out` stays 0 under later clock and data activity.
- R4: In Manchester mode, each rising-edge pulse samples `sda`. From the cycle after the rise, `mod_out` equals the sampled bit. From the cycle after the following falling-edge pulse, it equals the inverse of that bit.
- R5: In Bi-phase mode, `mod_out` inverts in the cycle after every rising-edge pulse. It inverts again in the cycle after the falling-edge pulse only if the sampled bit is 0. At all other times it holds.
- R6: Bits stream with no gap or pause at any count. Bit 9 and the bits after it encode the same way as the first eight.
- R7: A STOP pulse forces `mod_out` to 0 in the next cycle and ends streaming, even if an edge pulse arrives in the same cycle. After that, edge pulses have no effect until a new valid command.
- R8: A command strobe that arrives while streaming is ignored, and the selected code stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_byte | input | 8 | Command byte received after START |
| cmd_strobe | input | 1 | One-cycle pulse: `cmd_byte` is valid and acknowledged |
| scl_rise | input | 1 | One-cycle pulse on a serial clock rising edge |
| scl_fall | input | 1 | One-cycle pulse on a serial clock falling edge |
| sda | input | 1 | Serial data level |
| stop_det | input | 1 | One-cycle pulse on a STOP condition |
| mod_out | output | 1 | Damping control, 1 = damped |

## Verification
Each code is driven with alternating bits, runs of ones, runs of zeros, and mixed words of 8, 12 and 16 bits. Checking both half-bits of every bit separates a wrong sampling edge, a missing mid-bit toggle, and a level that is carried wrongly across bit boundaries. The streams longer than eight bits show that there is no acknowledge gap. Command bytes with the don't-care bit set and cleared, several non-matching bytes, a second strobe during streaming, and a STOP that coincides with a clock edge separate the decode, the code lock and the exit priority.

// File: rtl/clm_pkg.sv
package clm_pkg;
  typedef enum logic {
    CODE_BIPHASE    = 1'b0,
    CODE_MANCHESTER = 1'b1
  } line_code_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_STREAM = 1'b1
  } mod_state_e;
endpackage

// File: rtl/clm_cmd_decode.sv
module clm_cmd_decode #(
  parameter int unsigned CMD_W   = 8,
  parameter logic [CMD_W-1:0] MATCH_MASK = 8'b1110_0111,
  parameter logic [CMD_W-1:0] MATCH_VAL  = 8'b1100_0111,
  parameter int unsigned SEL_BIT = 4
) (
  input  logic [CMD_W-1:0]   cmd_byte,
  output logic               is_mod_cmd,
  output clm_pkg::line_code_e code_sel
);
  // Bit 3 is outside the mask, so it does not take part in the match.
  always_comb begin
    is_mod_cmd = ((cmd_byte & MATCH_MASK) == MATCH_VAL);
    code_sel   = cmd_byte[SEL_BIT] ? clm_pkg::CODE_MANCHESTER : clm_pkg::CODE_BIPHASE;
  end
endmodule

// File: rtl/clm_seq.sv
module clm_seq (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_strobe,
  input  logic                is_mod_cmd,
  input  clm_pkg::line_code_e code_sel,
  input  logic                stop_det,
  output logic                streaming,
  output clm_pkg::line_code_e code_q
);
  clm_pkg::mod_state_e state_q, state_d;
  clm_pkg::line_code_e code_d;
  logic                load_en;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    load_en = 1'b0;
    if (stop_det) begin
      state_d = clm_pkg::ST_IDLE;
    end else if (state_q == clm_pkg::ST_IDLE && cmd_strobe && is_mod_cmd) begin
      state_d = clm_pkg::ST_STREAM;
      load_en = 1'b1;
    end
    if (load_en) code_d = code_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= clm_pkg::ST_IDLE;
      code_q  <= clm_pkg::CODE_BIPHASE;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end

  assign streaming = (state_q == clm_pkg::ST_STREAM);
endmodule

// File: rtl/clm_encoder.sv
module clm_encoder (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                streaming,
  input  clm_pkg::line_code_e code_q,
  input  logic                stop_det,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                sda,
  output logic                mod_out
);
  logic out_q, out_d;
  logic bit_q, bit_d;
  logic manch;

  always_comb begin
    manch = (code_q == clm_pkg::CODE_MANCHESTER);
    out_d = out_q;
    bit_d = bit_q;
    if (!streaming || stop_det) begin
      out_d = 1'b0;
    end else if (scl_rise) begin
      bit_d = sda;
      out_d = manch ? sda : ~out_q;
    end else if (scl_fall) begin
      if (manch)       out_d = ~bit_q;
      else if (!bit_q) out_d = ~out_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      out_q <= out_d;
      bit_q <= bit_d;
    end
  end

  assign mod_out = out_q;
endmodule

// File: rtl/coil_line_modulator.sv
module coil_line_modulator #(
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             cmd_strobe,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda,
  input  logic             stop_det,
  output logic             mod_out
);
  localparam int unsigned SEL_BIT = CMD_W - 4;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  logic                   is_mod_cmd;
  logic                   streaming;
  clm_pkg::line_code_e    code_sel, code_q;

  // The reset asserts at once and releases in step with the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  clm_cmd_decode #(.CMD_W(CMD_W), .SEL_BIT(SEL_BIT)) u_decode (
    .cmd_byte  (cmd_byte),
    .is_mod_cmd(is_mod_cmd),
    .code_sel  (code_sel)
  );

  clm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_strobe(cmd_strobe),
    .is_mod_cmd(is_mod_cmd),
    .code_sel  (code_sel),
    .stop_det  (stop_det),
    .streaming (streaming),
    .code_q    (code_q)
  );

  clm_encoder u_enc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .streaming(streaming),
    .code_q   (code_q),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda      (sda),
    .mod_out  (mod_out)
  );
endmodule

// File: rtl/clm_checker.sv
module clm_checker (
  input logic                clk,
  input logic                rst_int_n,
  input logic                streaming,
  input clm_pkg::line_code_e code_q,
  input logic                cmd_strobe,
  input logic                stop_det,
  input logic                scl_rise,
  input logic                scl_fall,
  input logic                sda,
  input logic                mod_out
);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!streaming && !cmd_strobe) |=> !mod_out);

  assert_stop_exit_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    stop_det |=> (!streaming && !mod_out));

  assert_manch_first_half_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (streaming && code_q == clm_pkg::CODE_MANCHESTER && scl_rise && !stop_det)
      |=> (mod_out == $past(sda)));

  assert_biphase_edge_toggle_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (streaming && code_q == clm_pkg::CODE_BIPHASE && scl_rise && !stop_det)
      |=> (mod_out != $past(mod_out)));

  assert_hold_between_edges_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (streaming && !scl_rise && !scl_fall && !stop_det) |=> $stable(mod_out));

  assert_code_locked_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (streaming && !stop_det) |=> $stable(code_q));
endmodule

bind coil_line_modulator clm_checker u_clm_checker (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .streaming (streaming),
  .code_q    (code_q),
  .cmd_strobe(cmd_strobe),
  .stop_det  (stop_det),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .sda       (sda),
  .mod_out   (mod_out)
);

// File: tb/coil_line_modulator_bench.sv
module coil_line_modulator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // [31:24] command byte, [20:16] bit count, [15:0] bits, sent MSB first
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    {8'hC7, 3'b0, 5'd8,  16'hA500},
    {8'hD7, 3'b0, 5'd8,  16'h3C00},
    {8'hCF, 3'b0, 5'd12, 16'hF0F0},
    {8'hDF, 3'b0, 5'd16, 16'h8001},
    {8'hC7, 3'b0, 5'd16, 16'h0000},
    {8'hD7, 3'b0, 5'd16, 16'hFFFF}
  };

  logic       clk, rst_n;
  logic [7:0] cmd_byte;
  logic       cmd_strobe, scl_rise, scl_fall, sda, stop_det;
  logic       mod_out;
  int         checks, failures, cycles;
  logic       lvl;

  coil_line_modulator u_coil_line_modulator (
    .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .cmd_strobe(cmd_strobe),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda(sda),
    .stop_det(stop_det), .mod_out(mod_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic exp, input string req);
    checks++;
    if (mod_out !== exp) begin
      failures++;
      $display("FAIL %s mod_out=%b expected=%b", req, mod_out, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_byte = b; cmd_strobe = 1'b1;
    @(negedge clk); cmd_strobe = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
  endtask

  // One bit: rising pulse, two quiet cycles, falling pulse, two quiet cycles.
  // mode: 0 idle (expect 0), 1 Bi-phase, 2 Manchester.
  task automatic send_bit(input logic b, input int mode, input string req);
    @(negedge clk); sda = b; scl_rise = 1'b1;
    @(negedge clk); scl_rise = 1'b0;
    if (mode == 2) lvl = b; else if (mode == 1) lvl = ~lvl; else lvl = 1'b0;
    check(lvl, req);
    @(negedge clk); check(lvl, req);
    @(negedge clk); scl_fall = 1'b1;
    @(negedge clk); scl_fall = 1'b0;
    if (mode == 2) lvl = ~b; else if (mode == 1 && !b) lvl = ~lvl;
    check(lvl, req);
    @(negedge clk); check(lvl, req);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    checks = 0; failures = 0; lvl = 1'b0;
    cmd_byte = '0; cmd_strobe = 0; scl_rise = 0; scl_fall = 0; sda = 0; stop_det = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1'b0, "R1 reset level");
    send_bit(1'b1, 0, "R1 edges before any command");

    // Table of streams: R2 decode, R4/R5 coding, R6 long streams
    for (int v = 0; v < NVEC; v++) begin
      int mode;
      mode = VEC[v][28] ? 2 : 1;
      send_cmd(VEC[v][31:24]);
      lvl = 1'b0;
      check(1'b0, "R2 level on entry");
      for (int i = 0; i < int'(VEC[v][20:16]); i++)
        send_bit(VEC[v][15-i], mode, (mode == 2) ? "R4 Manchester / R6" : "R5 Bi-phase / R6");
      send_stop();
      check(1'b0, "R7 after stop");
      send_bit(1'b0, 0, "R7 edges after stop");
    end

    // R3: non-matching commands have no effect
    send_cmd(8'hA7); send_bit(1'b1, 0, "R3 byte A7"); send_bit(1'b0, 0, "R3 byte A7");
    send_cmd(8'hC6); send_bit(1'b1, 0, "R3 byte C6");
    send_cmd(8'hE7); send_bit(1'b0, 0, "R3 byte E7");
    send_cmd(8'hD3); send_bit(1'b1, 0, "R3 byte D3");
    send_stop();

    // R8: second strobe during Manchester streaming is ignored
    send_cmd(8'hD7); lvl = 1'b0;
    send_bit(1'b1, 2, "R8 before strobe");
    send_cmd(8'hC7);
    send_bit(1'b1, 2, "R8 code kept");
    send_bit(1'b0, 2, "R8 code kept");
    send_stop();

    // R7: stop together with a rising edge, Bi-phase
    send_cmd(8'hC7); lvl = 1'b0;
    send_bit(1'b1, 1, "R7 setup");
    @(negedge clk); stop_det = 1'b1; scl_rise = 1'b1; sda = 1'b1;
    @(negedge clk); stop_det = 1'b0; scl_rise = 1'b0;
    check(1'b0, "R7 stop wins over edge");
    send_bit(1'b1, 0, "R7 no effect after stop");

    // R1: reset in the middle of a stream
    send_cmd(8'hD7); lvl = 1'b0;
    send_bit(1'b1, 2, "R1 setup");
    @(negedge clk); sda = 1'b1; scl_rise = 1'b1;
    @(negedge clk); scl_rise = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); check(1'b0, "R1 async reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_bit(1'b1, 0, "R1 idle after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule